// File: doc/BRIEF.md
# Conditional-Execution Accumulator Core

This block is a very small processor that runs a short program of 6-bit instructions held in a local 16-entry program store. It keeps an 8-bit accumulator, a program counter, a zero flag derived from the accumulator, and two mode bits of its own. Each instruction carries a 2-bit parameter (cargo), a 2-bit condition code and a 2-bit opcode. The condition code picks which of two opcode rows applies. Two of its values gate the second row on the zero flag or on an external flag input.

The core executes its internal instructions in a single cycle each: halt or loop-back, the recognition marker, accumulator preset and the mode-flag write. The four instructions that reach other cores are Load, Store, Call and the remote flag write. Each of these leaves the block as a request on a valid/ready channel. The core then waits for a one-cycle response that carries a found bit and a data byte. The neighbourhood logic that matches partners and moves data is outside this block. Software writes a program through a plain write port and starts it with a launch pulse. The core runs until it halts.

The request channel follows valid/ready rules. Once the core raises `req_valid`, it holds the signal and the request fields stable until it samples `req_ready` high at a clock edge. The partner may hold `req_ready` low for any number of cycles. The response has no back-pressure. The core waits for a response after every accepted request, and `rsp_valid` is taken on the first cycle it is high.

Top module: `cond_acc_core`

## Requirements
- R1: An instruction word is {cargo[5:4], cond[3:2], op[1:0]}. After reset the core is halted, `pc`=0, `acc`=0, `zero_flag`=1, both mode bits are 0 and `req_valid`=0.
- R2: A `launch` pulse while halted sets `pc` to 0 and starts the core on the next cycle. An internal instruction then completes in one cycle. `pc` goes to 0 after address `prog_last`, and otherwise increments.
- R3: With cond=00, op=0 (End) halts the core when `cycle_mode`=0 and leaves `pc` on the End. op=1 (Site) only advances `pc`.
- R4: With `cycle_mode`=1, End sets `pc` to 0 and execution continues.
- R5: With cond=01, op=0 (SetAccu) writes the zero-extended cargo into `acc`. `zero_flag` is 1 exactly when `acc` is 0.
- R6: cond=10 executes the cond=01 opcode only if `zero_flag`=1. cond=11 executes it only if `pf1_in`=1. Otherwise the instruction has no effect and `pc` advances.
- R7: With cond=01, op=3 (SetFB) sets `cycle_mode` to cargo bit 0 and `reverse_mode` to cargo bit 1.
- R8: Load (00/op2), Store (00/op3), Call (01/op1) and SetFA (01/op2) raise `req_valid` with `req_kind` set to 0, 1, 2 and 3 respectively, the cargo and the accumulator. The request holds stable until `req_ready`, and `pc` does not move until the response.
- R9: A Load response with found=1 writes `rsp_data` into `acc`. With found=0, `acc` is unchanged and execution continues.
- R10: A Store with cargo=1 that returns found=0 halts the core. Any other Store response continues execution.
- R11: A Call with found=1 halts the caller, and with found=0 it continues. SetFA continues whatever the found bit.
- R12: While halted, `acc` and `pc` hold their values and no request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| launch | input | 1 | Start pulse, effective while halted |
| pf1_in | input | 1 | External communication flag for cond=11 |
| prog_we | input | 1 | Program store write enable |
| prog_addr | input | 4 | Program store write address |
| prog_data | input | 6 | Program store write data |
| prog_last | input | 4 | Last program address before wrap |
| req_valid | output | 1 | Attachment request valid |
| req_ready | input | 1 | Partner accepts request |
| req_kind | output | 2 | 0 Load, 1 Store, 2 Call, 3 SetFA |
| req_cargo | output | 2 | Cargo of requesting instruction |
| req_acc | output | 8 | Accumulator value sent with request |
| rsp_valid | input | 1 | One-cycle response strobe |
| rsp_found | input | 1 | Partner found |
| rsp_data | input | 8 | Data returned for Load |
| halted | output | 1 | Core stopped |
| pc | output | 4 | Program counter |
| acc | output | 8 | Accumulator |
| zero_flag | output | 1 | Accumulator equals zero |
| cycle_mode | output | 1 | End loops to address 0 |
| reverse_mode | output | 1 | Reverse access direction mode bit |

## Verification
The launch pulse registers at one clock edge, and `pc` reads 0 just after that edge. Each internal instruction's result then appears one edge after it executes. The bench therefore reads `pc` and the flags at each falling edge to follow the program step by step. An external instruction costs at least three edges: one to raise the request, one for the handshake and one to take the response. The responder in the bench answers on the falling edge after a handshake. The checks on an end result wait for `halted`, which has a cycle limit, and sample on a falling edge after that.

// File: rtl/cac_pkg.sv
package cac_pkg;
  localparam int CARGO_W = 2;
  localparam int INSTR_W = CARGO_W + 4;

  typedef enum logic [2:0] {
    EX_SKIP, EX_END, EX_SITE, EX_SETACC, EX_SETFB, EX_EXT
  } exec_e;

  typedef enum logic [1:0] {
    XR_LOAD = 2'd0, XR_STORE = 2'd1, XR_CALL = 2'd2, XR_SETFA = 2'd3
  } ext_e;

  typedef enum logic [1:0] {
    ST_HALT, ST_RUN, ST_REQ, ST_WAIT
  } core_st_e;
endpackage

// File: rtl/cac_progmem.sv
module cac_progmem #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 6,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/cac_decode.sv
module cac_decode
  import cac_pkg::*;
(
  input  logic [1:0] cond,
  input  logic [1:0] op,
  input  logic       zf,
  input  logic       pf1,
  output exec_e      kind,
  output ext_e       ext_op
);
  logic row2_en;

  always_comb begin
    case (cond)
      2'b01:   row2_en = 1'b1;
      2'b10:   row2_en = zf;
      2'b11:   row2_en = pf1;
      default: row2_en = 1'b0;
    endcase
  end

  always_comb begin
    kind   = EX_SKIP;
    ext_op = XR_LOAD;
    if (cond == 2'b00) begin
      case (op)
        2'd0: kind = EX_END;
        2'd1: kind = EX_SITE;
        2'd2: begin kind = EX_EXT; ext_op = XR_LOAD;  end
        default: begin kind = EX_EXT; ext_op = XR_STORE; end
      endcase
    end else if (row2_en) begin
      case (op)
        2'd0: kind = EX_SETACC;
        2'd1: begin kind = EX_EXT; ext_op = XR_CALL;  end
        2'd2: begin kind = EX_EXT; ext_op = XR_SETFA; end
        default: kind = EX_SETFB;
      endcase
    end
  end
endmodule

// File: rtl/cond_acc_core.sv
module cond_acc_core
  import cac_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int ACC_W = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               launch,
  input  logic               pf1_in,
  input  logic               prog_we,
  input  logic [AW-1:0]      prog_addr,
  input  logic [INSTR_W-1:0] prog_data,
  input  logic [AW-1:0]      prog_last,
  output logic               req_valid,
  input  logic               req_ready,
  output logic [1:0]         req_kind,
  output logic [CARGO_W-1:0] req_cargo,
  output logic [ACC_W-1:0]   req_acc,
  input  logic               rsp_valid,
  input  logic               rsp_found,
  input  logic [ACC_W-1:0]   rsp_data,
  output logic               halted,
  output logic [AW-1:0]      pc,
  output logic [ACC_W-1:0]   acc,
  output logic               zero_flag,
  output logic               cycle_mode,
  output logic               reverse_mode
);
  core_st_e           state;
  logic [INSTR_W-1:0] instr;
  logic [CARGO_W-1:0] cargo;
  exec_e              kind;
  ext_e               ext_op;
  ext_e               r_kind;
  logic [CARGO_W-1:0] r_cargo;
  logic [AW-1:0]      pc_next;

  cac_progmem #(.DEPTH(DEPTH), .WIDTH(INSTR_W)) u_mem (
    .clk(clk), .we(prog_we), .waddr(prog_addr), .wdata(prog_data),
    .raddr(pc), .rdata(instr)
  );

  assign cargo = instr[INSTR_W-1:4];

  cac_decode u_dec (
    .cond(instr[3:2]), .op(instr[1:0]), .zf(zero_flag), .pf1(pf1_in),
    .kind(kind), .ext_op(ext_op)
  );

  assign pc_next   = (pc == prog_last) ? '0 : pc + 1'b1;
  assign zero_flag = (acc == '0);
  assign halted    = (state == ST_HALT);
  assign req_valid = (state == ST_REQ);
  assign req_kind  = r_kind;
  assign req_cargo = r_cargo;
  assign req_acc   = acc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= ST_HALT;
      pc           <= '0;
      acc          <= '0;
      cycle_mode   <= 1'b0;
      reverse_mode <= 1'b0;
      r_kind       <= XR_LOAD;
      r_cargo      <= '0;
    end else begin
      case (state)
        ST_HALT: if (launch) begin
          pc    <= '0;
          state <= ST_RUN;
        end
        ST_RUN: begin
          case (kind)
            EX_END: begin
              if (cycle_mode) pc <= '0;
              else            state <= ST_HALT;
            end
            EX_SETACC: begin
              acc <= ACC_W'(cargo);
              pc  <= pc_next;
            end
            EX_SETFB: begin
              cycle_mode   <= cargo[0];
              reverse_mode <= cargo[1];
              pc           <= pc_next;
            end
            EX_EXT: begin
              r_kind  <= ext_op;
              r_cargo <= cargo;
              state   <= ST_REQ;
            end
            default: pc <= pc_next;
          endcase
        end
        ST_REQ: if (req_ready) state <= ST_WAIT;
        ST_WAIT: if (rsp_valid) begin
          state <= ST_RUN;
          pc    <= pc_next;
          case (r_kind)
            XR_LOAD: if (rsp_found) acc <= rsp_data;
            XR_STORE: if (!rsp_found && r_cargo == CARGO_W'(1)) begin
              state <= ST_HALT;
              pc    <= pc;
            end
            XR_CALL: if (rsp_found) begin
              state <= ST_HALT;
              pc    <= pc;
            end
            default: ;
          endcase
        end
        default: state <= ST_HALT;
      endcase
    end
  end

  assert_req_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_kind) &&
      $stable(req_cargo) && $stable(req_acc))
    else $error("request changed while stalled");

  assert_no_req_halted_R12: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !req_valid)
    else $error("request while halted");

  assert_halt_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    halted && !launch |=> halted && $stable(acc) && $stable(pc))
    else $error("state moved while halted");

  assert_launch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    halted && launch |=> !halted && pc == '0)
    else $error("launch did not restart at 0");

  assert_load_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_WAIT && rsp_valid && rsp_found && r_kind == XR_LOAD
      |=> acc == $past(rsp_data))
    else $error("load data not taken");
endmodule

// File: tb/cond_acc_core_test.sv
module cond_acc_core_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, launch = 1'b0, pf1_in = 1'b0;
  logic prog_we = 1'b0;
  logic [3:0] prog_addr = '0, prog_last = 4'd15;
  logic [5:0] prog_data = '0;
  logic req_valid, req_ready = 1'b1;
  logic [1:0] req_kind, req_cargo;
  logic [7:0] req_acc;
  logic rsp_valid = 1'b0, rsp_found = 1'b0;
  logic [7:0] rsp_data = '0;
  logic halted, zero_flag, cycle_mode, reverse_mode;
  logic [3:0] pc;
  logic [7:0] acc;

  int tests = 0, fails = 0, reqs = 0;
  logic cfg_ready = 1'b1, cfg_found = 1'b0;
  logic [7:0] cfg_data = '0;
  logic [1:0] cap_kind = '0, cap_cargo = '0;
  logic [7:0] cap_acc = '0;
  logic pend = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cond_acc_core uut (
    .clk(clk), .rst_n(rst_n), .launch(launch), .pf1_in(pf1_in),
    .prog_we(prog_we), .prog_addr(prog_addr), .prog_data(prog_data),
    .prog_last(prog_last), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_cargo(req_cargo), .req_acc(req_acc),
    .rsp_valid(rsp_valid), .rsp_found(rsp_found), .rsp_data(rsp_data),
    .halted(halted), .pc(pc), .acc(acc), .zero_flag(zero_flag),
    .cycle_mode(cycle_mode), .reverse_mode(reverse_mode)
  );

  // partner model: answers one falling edge after a handshake
  initial forever begin
    @(negedge clk);
    rsp_valid = 1'b0;
    req_ready = cfg_ready;
    if (pend) begin
      rsp_valid = 1'b1; rsp_found = cfg_found; rsp_data = cfg_data; pend = 1'b0;
    end else if (req_valid && req_ready) begin
      cap_kind = req_kind; cap_cargo = req_cargo; cap_acc = req_acc;
      reqs++; pend = 1'b1;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog R2: actual=timeout expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  function automatic logic [5:0] ins(input int cargo, input int cond, input int op);
    return {2'(cargo), 2'(cond), 2'(op)};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [5:0] d);
    @(negedge clk);
    prog_we = 1'b1; prog_addr = 4'(a); prog_data = d;
    @(negedge clk);
    prog_we = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
    prog_last = 4'd15;
  endtask

  task automatic kick();
    @(negedge clk); launch = 1'b1;
    @(negedge clk); launch = 1'b0;
  endtask

  task automatic wait_halt();
    for (int i = 0; i < 200 && !halted; i++) @(negedge clk);
    chk("R2 run completes", 32'(halted), 1);
  endtask

  task automatic t_reset();
    chk("R1 halted", 32'(halted), 1);
    chk("R1 pc", 32'(pc), 0);
    chk("R1 acc", 32'(acc), 0);
    chk("R1 zero_flag", 32'(zero_flag), 1);
    chk("R1 modes", {30'd0, cycle_mode, reverse_mode}, 0);
    chk("R1 req_valid", 32'(req_valid), 0);
  endtask

  task automatic t_step();
    wr(0, ins(0,0,1)); wr(1, ins(0,0,1)); wr(2, ins(3,1,0)); wr(3, ins(0,0,0));
    kick();
    chk("R2 launch pc", 32'(pc), 0);
    chk("R2 running", 32'(halted), 0);
    @(negedge clk); chk("R3 site advance", 32'(pc), 1);
    @(negedge clk); chk("R3 site advance", 32'(pc), 2);
    @(negedge clk); chk("R5 setaccu pc", 32'(pc), 3);
    chk("R5 setaccu acc", 32'(acc), 3);
    @(negedge clk); chk("R3 end halts", 32'(halted), 1);
    chk("R3 end pc held", 32'(pc), 3);
    chk("R5 zero_flag low", 32'(zero_flag), 0);
  endtask

  task automatic t_halt_quiet();
    int r0 = reqs;
    repeat (6) @(negedge clk);
    chk("R12 acc held", 32'(acc), 3);
    chk("R12 pc held", 32'(pc), 3);
    chk("R12 no request", 32'(reqs), 32'(r0));
  endtask

  task automatic t_wrap();
    wr(0, ins(0,0,1)); wr(1, ins(0,0,1)); wr(2, ins(0,0,1));
    prog_last = 4'd2;
    kick();
    @(negedge clk); @(negedge clk); @(negedge clk);
    chk("R2 wrap to 0", 32'(pc), 0);
    @(negedge clk); chk("R2 after wrap", 32'(pc), 1);
    do_reset();
  endtask

  task automatic t_cycle();
    wr(0, ins(1,1,3)); wr(1, ins(0,0,0));
    kick();
    @(negedge clk); chk("R7 cycle bit set", 32'(cycle_mode), 1);
    @(negedge clk); chk("R4 end loops pc", 32'(pc), 0);
    chk("R4 still running", 32'(halted), 0);
    @(negedge clk); chk("R4 continues", 32'(pc), 1);
    do_reset();
  endtask

  task automatic t_setfb();
    wr(0, ins(2,1,3)); wr(1, ins(0,0,0));
    kick(); wait_halt();
    chk("R7 reverse bit", 32'(reverse_mode), 1);
    chk("R7 cycle bit", 32'(cycle_mode), 0);
  endtask

  task automatic t_cond_zf();
    wr(0, ins(0,1,0)); wr(1, ins(3,2,0)); wr(2, ins(1,2,0)); wr(3, ins(0,0,0));
    kick(); wait_halt();
    chk("R6 zf gated exec/skip", 32'(acc), 3);
    chk("R6 skip advances", 32'(pc), 3);
  endtask

  task automatic t_cond_pf1();
    wr(0, ins(2,3,0)); wr(1, ins(1,2,3)); wr(2, ins(0,0,0));
    pf1_in = 1'b0;
    kick(); wait_halt();
    chk("R6 pf1 low skips", 32'(acc), 3);
    chk("R6 zf low skips setfb", 32'(reverse_mode), 1);
    pf1_in = 1'b1;
    kick(); wait_halt();
    chk("R6 pf1 high executes", 32'(acc), 2);
    pf1_in = 1'b0;
  endtask

  task automatic t_load();
    wr(0, ins(0,0,2)); wr(1, ins(0,0,0));
    cfg_found = 1'b1; cfg_data = 8'hA5;
    kick(); wait_halt();
    chk("R9 load found", 32'(acc), 32'hA5);
    chk("R8 load kind", 32'(cap_kind), 0);
    chk("R8 load cargo", 32'(cap_cargo), 0);
    cfg_found = 1'b0; cfg_data = 8'h11;
    kick(); wait_halt();
    chk("R9 load miss keeps acc", 32'(acc), 32'hA5);
    chk("R9 load miss continues", 32'(pc), 1);
  endtask

  task automatic t_store();
    wr(0, ins(1,1,0)); wr(1, ins(1,0,3)); wr(2, ins(2,1,0)); wr(3, ins(0,0,0));
    cfg_found = 1'b0;
    kick(); wait_halt();
    chk("R10 store miss reg1 halts", 32'(pc), 1);
    chk("R10 acc at stop", 32'(acc), 1);
    chk("R8 store kind", 32'(cap_kind), 1);
    chk("R8 store acc", 32'(cap_acc), 1);
    wr(1, ins(0,0,3));
    kick(); wait_halt();
    chk("R10 store miss reg0 continues", 32'(acc), 2);
  endtask

  task automatic t_call();
    wr(0, ins(2,1,1)); wr(1, ins(3,1,0)); wr(2, ins(0,0,0));
    cfg_found = 1'b1;
    kick(); wait_halt();
    chk("R11 call found halts", 32'(pc), 0);
    chk("R11 call found acc", 32'(acc), 2);
    chk("R8 call kind/cargo", {28'd0, cap_kind, cap_cargo}, 32'hA);
    cfg_found = 1'b0;
    kick(); wait_halt();
    chk("R11 call miss continues", 32'(acc), 3);
  endtask

  task automatic t_setfa();
    wr(0, ins(3,1,2)); wr(1, ins(0,0,0));
    cfg_found = 1'b0;
    kick(); wait_halt();
    chk("R11 setfa continues", 32'(pc), 1);
    chk("R8 setfa kind/cargo", {28'd0, cap_kind, cap_cargo}, 32'hF);
  endtask

  task automatic t_backpressure();
    wr(0, ins(2,0,2)); wr(1, ins(0,0,0));
    cfg_found = 1'b1; cfg_data = 8'h07; cfg_ready = 1'b0;
    kick();
    repeat (4) @(negedge clk);
    chk("R8 valid held", 32'(req_valid), 1);
    chk("R8 fields held", {28'd0, req_kind, req_cargo}, 32'h2);
    chk("R8 pc frozen", 32'(pc), 0);
    cfg_ready = 1'b1;
    wait_halt();
    chk("R8 completes after ready", 32'(acc), 7);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_step();
    t_halt_quiet();
    t_wrap();
    t_cycle();
    t_setfb();
    t_cond_zf();
    t_cond_pf1();
    t_load();
    t_store();
    t_call();
    t_setfa();
    t_backpressure();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule